// File: doc/BRIEF.md
# SIMD Saturating Rounding Multiply-High Unit

This block carries out a signed multiply of every lane of a 128-bit vector by one lane picked out of a second 128-bit operand. Each product is doubled, rounded to nearest with ties going up, cut down to its upper half, and then clamped to the signed lane range. Lanes are 16 or 32 bits wide. The operation works on a full 128-bit vector, on the lower 64 bits only, or on a single scalar element.

The request is the upper part of the instruction word, bits 31 down to 10. The register-number fields below bit 10 are handled outside the block. The unit decodes the lane width, the lane count, the lane index and the second register number from that word, and it reports encodings it does not accept as undefined.

Results leave one cycle after the request is accepted. Each result carries a flag that is set when any active lane saturated. A sticky cumulative saturation flag gathers those events until software clears it with a synchronous clear input. Every path through the datapath is the same length for all operand values, so the latency never depends on the data.

Top module: `sq_mulhi_unit`

## Requirements
- R1: With size=01 (16-bit lanes), each active lane gives (2·a·b + 2^15) >>> 16, taking b from lane {H,L,M} of `src_b` (bits idx·16 upward).
- R2: With size=10 (32-bit lanes), each active lane gives (2·a·b + 2^31) >>> 32, taking b from lane {H,L} of `src_b`.
- R3: In vector form (bit 28 = 0) with Q (bit 30) = 1, all 128 bits are computed. With Q=0, only the low 64 bits are computed and bits 127:64 of the result are zero.
- R4: In scalar form (bit 28 = 1), only lane 0 is computed and every result bit above it is zero.
- R5: A lane that saturates gives the most positive lane value, and `out_sat` is 1 when any active lane saturated. Saturation only happens when both a and b equal the most negative value.
- R6: `sticky_sat` becomes 1 after any saturating operation. No operation clears it. `sat_clr` clears it. When a clear and a saturating operation meet in one cycle, the flag ends at 1.
- R7: The request is undefined when size is 00 or 11, or when the fixed bits differ from the pattern. The pattern is: bit31=0, bit29=0, bits27:24=1111, bits15:12=1101, bit10=0, and bit30=1 in scalar form. An undefined request gives `out_undef`=1, data 0, `out_sat`=0 and register number 0, and it leaves the sticky flag unchanged apart from a clear.
- R8: `out_valid` follows `in_valid` exactly one cycle later. After reset, `out_valid`, `out_data` and `sticky_sat` are 0.
- R9: `out_regm` is {0,Rm} (bits 19:16) for 16-bit lanes and {M,Rm} (bit 20, bits 19:16) for 32-bit lanes.
- R10: Rounding breaks ties upward. For example, 16-bit a=1 with b=0x4000 gives 1, and a=-1 with b=0x4000 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| op_word | input | 22 | Instruction word bits 31:10 |
| src_a | input | 128 | Multiplicand vector |
| src_b | input | 128 | Operand holding the indexed lane |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 128 | Destination vector |
| out_sat | output | 1 | This operation saturated |
| out_undef | output | 1 | Encoding not accepted |
| out_regm | output | 5 | Decoded second register number |
| sticky_sat | output | 1 | Cumulative saturation flag |

## Verification
Two events can land on the same edge: the software clear of the cumulative flag, and an operation that saturates. The bench drives `sat_clr` together with a most-negative-squared request, and expects the flag to read 1 when that result appears. It then pairs a clear with a non-saturating request and with an idle cycle, and expects the flag to read 0. The scoreboard model applies the set-over-clear rule on its own terms, so any change in priority shows up as a flag mismatch on the next result.

// File: rtl/smh_pkg.sv
// Package: shared widths and the decoded-request record for the
// multiply-high unit. Assumes the 128-bit vector register width.
package smh_pkg;
    localparam int DATA_W   = 128;
    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int IDX_W    = 3;   // widest lane index carried by the format
    localparam int REG_W    = 5;

    typedef struct packed {
        logic             undef;   // reserved size or wrong fixed bits
        logic             wide;    // 32-bit lanes when set
        logic             scalar;  // single element form
        logic             q;       // full 128-bit vector when set
        logic [IDX_W-1:0] index;   // selected lane of the indexed operand
        logic [REG_W-1:0] regm;    // second register number
    } smh_dec_t;
endpackage

// File: rtl/smh_decode.sv
// Decoder: turns instruction bits 31:10 into lane width, form, index and
// register number. Assumes the caller handles Rn/Rd (bits 9:0).
module smh_decode
    import smh_pkg::*;
(
    input  logic [31:10] op_word,
    output smh_dec_t     dec
);
    logic [1:0] size;
    logic       fixed_ok;
    logic       bad_size;

    // Purpose: check fixed opcode bits and the size field.
    always_comb begin
        size     = op_word[23:22];
        fixed_ok = !op_word[31] && !op_word[29]
                   && (op_word[27:24] == 4'hF)
                   && (op_word[15:12] == 4'hD)
                   && !op_word[10]
                   && (!op_word[28] || op_word[30]);
        bad_size = (size == 2'b00) || (size == 2'b11);
    end

    // Purpose: build the decoded record.
    always_comb begin
        dec.undef  = !fixed_ok || bad_size;
        dec.wide   = (size == 2'b10);
        dec.scalar = op_word[28];
        dec.q      = op_word[30];
        if (dec.wide) begin
            dec.index = {1'b0, op_word[11], op_word[21]};
            dec.regm  = {op_word[20], op_word[19:16]};
        end else begin
            dec.index = {op_word[11], op_word[21], op_word[20]};
            dec.regm  = {1'b0, op_word[19:16]};
        end
        if (dec.undef) dec.regm = '0;
    end
endmodule

// File: rtl/smh_lane.sv
// One lane: signed doubling multiply, round-half-up, keep high half,
// clamp to the signed lane range. Assumes EW >= 2. Pure combinational.
module smh_lane #(
    parameter int EW = 16
) (
    input  logic signed [EW-1:0] a,
    input  logic signed [EW-1:0] b,
    output logic        [EW-1:0] res,
    output logic                 sat
);
    localparam int PW = 2 * EW + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (EW - 1);
    localparam logic signed [PW-1:0] MAXV = HALF - PW'(1);
    localparam logic signed [PW-1:0] MINV = -HALF;
    localparam logic        [EW-1:0] MOST_NEG = {1'b1, {(EW-1){1'b0}}};

    logic signed [PW-1:0] a_x, b_x, prod, rnd, shr;
    logic                 hi, lo;

    // Purpose: widen, multiply, double, round and shift.
    always_comb begin
        a_x  = PW'(a);
        b_x  = PW'(b);
        prod = a_x * b_x;
        rnd  = (prod <<< 1) + HALF;
        shr  = rnd >>> EW;
    end

    // Purpose: clamp the shifted value to the lane range.
    always_comb begin
        hi  = shr > MAXV;
        lo  = shr < MINV;
        sat = hi || lo;
        if (hi)      res = MAXV[EW-1:0];
        else if (lo) res = MINV[EW-1:0];
        else         res = shr[EW-1:0];
    end

    // Purpose: saturation only from most-negative squared.
    always_comb begin
        // R5
        sat_only_minsq_chk: assert (!sat || (a == MOST_NEG && b == MOST_NEG));
    end
endmodule

// File: rtl/smh_bank.sv
// Lane bank for one lane width: selects the indexed element, fans it out
// to DW/EW lanes and zeroes lanes outside the active set.
// Assumes DW is a multiple of EW.
module smh_bank #(
    parameter int DW = 128,
    parameter int EW = 16
) (
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [$clog2(DW/EW)-1:0] idx,
    input  logic          scalar,
    input  logic          half,
    output logic [DW-1:0] res,
    output logic          sat_any
);
    localparam int NL = DW / EW;

    logic [EW-1:0] b_sel;
    logic [NL-1:0] sat_vec;

    // Purpose: pick the broadcast element from the indexed operand.
    always_comb b_sel = src_b[idx*EW +: EW];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic          en;
        logic [EW-1:0] r;
        logic          s;

        smh_lane #(.EW(EW)) u_lane (
            .a   (src_a[g*EW +: EW]),
            .b   (b_sel),
            .res (r),
            .sat (s)
        );

        // Purpose: gate the lane by the form and vector length.
        always_comb begin
            en                = scalar ? (g == 0) : (!half || (g < NL / 2));
            res[g*EW +: EW]   = en ? r : '0;
            sat_vec[g]        = en && s;
        end
    end

    // Purpose: combine lane saturation.
    always_comb sat_any = |sat_vec;
endmodule

// File: rtl/sq_mulhi_unit.sv
// Top: decodes the request, runs both lane banks, chooses by width and
// registers the result with one-cycle latency. Keeps the sticky
// saturation flag; a same-cycle clear loses to a saturating operation.
module sq_mulhi_unit
    import smh_pkg::*;
#(
    parameter int DATA_WIDTH = smh_pkg::DATA_W,
    parameter int LANE_N_W   = smh_pkg::NARROW_W,
    parameter int LANE_W_W   = smh_pkg::WIDE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [31:10]          op_word,
    input  logic [DATA_WIDTH-1:0] src_a,
    input  logic [DATA_WIDTH-1:0] src_b,
    input  logic                  sat_clr,
    output logic                  out_valid,
    output logic [DATA_WIDTH-1:0] out_data,
    output logic                  out_sat,
    output logic                  out_undef,
    output logic [4:0]            out_regm,
    output logic                  sticky_sat
);
    localparam int NIW = $clog2(DATA_WIDTH / LANE_N_W);
    localparam int WIW = $clog2(DATA_WIDTH / LANE_W_W);

    smh_dec_t              dec;
    logic [DATA_WIDTH-1:0] n_res, w_res, sel_res;
    logic                  n_sat, w_sat, op_sat;

    smh_decode u_dec (.op_word(op_word), .dec(dec));

    smh_bank #(.DW(DATA_WIDTH), .EW(LANE_N_W)) u_narrow (
        .src_a(src_a), .src_b(src_b), .idx(dec.index[NIW-1:0]),
        .scalar(dec.scalar), .half(!dec.q), .res(n_res), .sat_any(n_sat)
    );

    smh_bank #(.DW(DATA_WIDTH), .EW(LANE_W_W)) u_wide (
        .src_a(src_a), .src_b(src_b), .idx(dec.index[WIW-1:0]),
        .scalar(dec.scalar), .half(!dec.q), .res(w_res), .sat_any(w_sat)
    );

    // Purpose: choose the bank result, suppress undefined requests.
    always_comb begin
        sel_res = dec.undef ? '0 : (dec.wide ? w_res : n_res);
        op_sat  = !dec.undef && (dec.wide ? w_sat : n_sat);
    end

    // Purpose: result register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sat   <= 1'b0;
            out_undef <= 1'b0;
            out_regm  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= sel_res;
                out_sat   <= op_sat;
                out_undef <= dec.undef;
                out_regm  <= dec.regm;
            end
        end
    end

    // Purpose: sticky flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sticky_sat <= 1'b0;
        else if (in_valid && op_sat)  sticky_sat <= 1'b1;
        else if (sat_clr)             sticky_sat <= 1'b0;
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_sat && !sat_clr |=> sticky_sat);
    // R6
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clr && !in_valid |=> !sticky_sat);
    // R7
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> (out_data == '0) && !out_sat && (out_regm == '0));
endmodule

// File: tb/sim_sq_mulhi_unit.sv
module sim_sq_mulhi_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         sat_clr = 1'b0;
    logic [31:10] op_word = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid, out_sat, out_undef, sticky_sat;
    logic [127:0] out_data;
    logic [4:0]   out_regm;

    typedef struct {
        logic [127:0] data;
        logic         sat;
        logic         undef;
        logic         sticky;
        logic [4:0]   regm;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   errs = 0;
    int   checks = 0;
    logic model_sticky = 1'b0;
    bit   done = 1'b0;

    sq_mulhi_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_word(op_word),
        .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat),
        .out_undef(out_undef), .out_regm(out_regm), .sticky_sat(sticky_sat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit sc, bit q, logic [1:0] sz,
                                       bit h, bit l, bit m, logic [3:0] rm);
        return {1'b0, (sc ? 1'b1 : q), 1'b0, sc, 4'hF, sz, l, m, rm,
                4'hD, h, 1'b0, 10'd0};
    endfunction

    function automatic exp_t model(logic [31:0] w, logic [127:0] a, logic [127:0] b);
        exp_t e;
        logic [1:0] sz;
        bit ok, wide, sc;
        int idx, lanes;
        logic signed [15:0] av16, bv16;
        logic signed [31:0] av32, bv32;
        logic signed [95:0] p;
        e.data = '0; e.sat = 0; e.regm = '0; e.sticky = 0; e.tag = "";
        sz = w[23:22];
        sc = w[28];
        ok = !w[31] && !w[29] && w[27:24] == 4'hF && w[15:12] == 4'hD
             && !w[10] && (!sc || w[30]);
        e.undef = !ok || sz == 2'b00 || sz == 2'b11;
        if (e.undef) return e;
        wide = (sz == 2'b10);
        if (wide) begin
            idx = {w[11], w[21]};
            e.regm = {w[20], w[19:16]};
            lanes = sc ? 1 : (w[30] ? 4 : 2);
            bv32 = b[idx*32 +: 32];
            for (int k = 0; k < lanes; k++) begin
                av32 = a[k*32 +: 32];
                p = 96'(av32) * 96'(bv32) * 2 + 96'sd2147483648;
                p = p >>> 32;
                if (p > 96'sd2147483647) begin p = 96'sd2147483647; e.sat = 1; end
                e.data[k*32 +: 32] = p[31:0];
            end
        end else begin
            idx = {w[11], w[21], w[20]};
            e.regm = {1'b0, w[19:16]};
            lanes = sc ? 1 : (w[30] ? 8 : 4);
            bv16 = b[idx*16 +: 16];
            for (int k = 0; k < lanes; k++) begin
                av16 = a[k*16 +: 16];
                p = 96'(av16) * 96'(bv16) * 2 + 96'sd32768;
                p = p >>> 16;
                if (p > 96'sd32767) begin p = 96'sd32767; e.sat = 1; end
                e.data[k*16 +: 16] = p[15:0];
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] w, input logic [127:0] a,
                         input logic [127:0] b, input bit clr, input string tag);
        exp_t e;
        @(negedge clk);
        op_word = w[31:10]; src_a = a; src_b = b; sat_clr = clr; in_valid = 1'b1;
        e = model(w, a, b);
        if (!e.undef && e.sat) model_sticky = 1'b1;
        else if (clr)          model_sticky = 1'b0;
        e.sticky = model_sticky;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input bit clr);
        @(negedge clk);
        in_valid = 1'b0; sat_clr = clr;
        if (clr) model_sticky = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R8", "valid without request", 128'(out_valid), 128'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_data == e.data, e.tag, "data", out_data, e.data);
                chk(out_sat == e.sat, "R5", "out_sat", 128'(out_sat), 128'(e.sat));
                chk(out_undef == e.undef, "R7", "out_undef", 128'(out_undef), 128'(e.undef));
                chk(sticky_sat == e.sticky, "R6", "sticky", 128'(sticky_sat), 128'(e.sticky));
                chk(out_regm == e.regm, "R9", "regm", 128'(out_regm), 128'(e.regm));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        logic [127:0] a, b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R8", "reset valid", 128'(out_valid), 128'(0));
        chk(sticky_sat == 0, "R8", "reset sticky", 128'(sticky_sat), 128'(0));
        chk(out_data == 0, "R8", "reset data", out_data, 128'(0));
        rst_n = 1'b1;

        // R1: 16-bit full vector, index 5
        drive(mk(0, 1, 2'b01, 1, 0, 1, 4'h9), rnd128(), rnd128(), 0, "R1");
        // R3: 16-bit half vector, index 2
        drive(mk(0, 0, 2'b01, 0, 1, 0, 4'h3), rnd128(), rnd128(), 0, "R3");
        // R2: 32-bit full vector, index 3, regm 23
        drive(mk(0, 1, 2'b10, 1, 1, 1, 4'h7), rnd128(), rnd128(), 0, "R2");
        // R3: 32-bit half vector
        drive(mk(0, 0, 2'b10, 0, 1, 0, 4'h2), rnd128(), rnd128(), 0, "R3");
        // R4: scalar forms
        drive(mk(1, 0, 2'b01, 1, 1, 1, 4'hF), rnd128(), rnd128(), 0, "R4");
        drive(mk(1, 0, 2'b10, 0, 0, 1, 4'h1), rnd128(), rnd128(), 0, "R4");
        // R10: ties round up
        a = '0; a[15:0] = 16'h0001; a[31:16] = 16'hFFFF; a[47:32] = 16'h0003;
        b = '0; b[15:0] = 16'h4000;
        drive(mk(0, 0, 2'b01, 0, 0, 0, 4'h0), a, b, 0, "R10");
        // R5: most negative squared, 16-bit
        a = rnd128(); a[15:0] = 16'h8000;
        b = rnd128(); b[15:0] = 16'h8000;
        drive(mk(0, 1, 2'b01, 0, 0, 0, 4'h0), a, b, 0, "R5");
        // R6: non-saturating op keeps the flag
        drive(mk(0, 1, 2'b01, 0, 0, 0, 4'h0), 128'h1, 128'h1, 0, "R6");
        // R7: reserved sizes and bad fixed bits
        drive(mk(0, 1, 2'b00, 0, 0, 0, 4'h5), a, b, 0, "R7");
        drive(mk(0, 1, 2'b11, 0, 0, 0, 4'h5), a, b, 0, "R7");
        drive(mk(0, 1, 2'b01, 0, 0, 0, 4'h5) ^ 32'h0000_1000, a, b, 0, "R7");
        // R6: idle clear, then a non-saturating op shows 0
        idle(1);
        drive(mk(0, 1, 2'b01, 0, 0, 0, 4'h0), 128'h5, 128'h7, 0, "R6");
        // R6: clear and saturation in the same cycle -> 1
        a = rnd128(); a[63:32] = 32'h8000_0000;
        b = rnd128(); b[95:64] = 32'h8000_0000;
        drive(mk(0, 1, 2'b10, 1, 0, 0, 4'h0), a, b, 1, "R6");
        // R6: clear with a non-saturating op -> 0
        drive(mk(0, 1, 2'b10, 0, 0, 0, 4'h0), 128'h3, 128'h3, 1, "R6");
        // R7: undefined op with clear clears, without set
        drive(mk(0, 1, 2'b00, 0, 0, 0, 4'h0), a, b, 1, "R7");
        // R1/R2: mixed back-to-back traffic
        for (int i = 0; i < 24; i++) begin
            logic [31:0] r;
            r = $urandom;
            a = rnd128(); b = rnd128();
            if (r[8]) begin a[15:0] = 16'h8000; b = {8{16'h8000}}; end
            drive(mk(r[0], r[1], r[2] ? 2'b10 : 2'b01, r[3], r[4], r[5], r[15:12]),
                  a, b, r[6] && r[7], r[2] ? "R2" : "R1");
        end
        idle(0); idle(0); idle(0);
        chk(sb.size() == 0, "R8", "pending results", 128'(sb.size()), 128'(0));
        chk(out_valid == 0, "R8", "idle valid", 128'(out_valid), 128'(0));
        done = 1'b1;
        summary();
        $finish;
    end
endmodule